// File: doc/BRIEF.md
# USB Endpoint Handshake Responder

This block sits inside one endpoint of a USB device and chooses the reply to each transaction. After the token phase ends, and the data phase too where the transaction has one, the surrounding logic pulses a strobe. With that strobe it presents the decoded PID, whether the token arrived intact and whether the data packet passed its CRC. It also presents the received data toggle, the endpoint type and whether the endpoint can supply or take data. One cycle later the block pulses a response strobe that carries a reply code: send data, ACK, NAK, STALL, or stay silent.

The block owns two pieces of endpoint state. The first is the halt (stall) condition, which software sets and clears. The second is the next expected data toggle for OUT data. The block raises a data-accept strobe when received data should be written into the endpoint buffer. It raises a toggle-reset strobe when a SETUP resynchronises the endpoint with the host. SETUP is handled differently from IN and OUT. A control endpoint acknowledges and accepts SETUP even when it is halted or busy. A non-control endpoint ignores SETUP completely.

Top module: `usb_ep_responder`

## Requirements
- R1: After reset, rsp_valid, data_accept and toggle_reset are 0, halted is 0 and exp_toggle is 0 (DATA0).
- R2: rsp_valid is 1 in exactly the cycle after each cycle in which phase_done is 1, and 0 otherwise. While rsp_valid is 0, rsp_code is 0. Codes: 0 none, 1 send data, 2 ACK, 3 NAK, 4 STALL. PID encoding: 0 OUT, 1 IN, 2 SETUP, 3 reserved.
- R3: If token_ok is 0, the reply is none, for every PID, and neither halted nor exp_toggle changes.
- R4: A valid IN token gets STALL if halted, otherwise NAK if ep_ready is 0, otherwise send data. data_crc_ok has no effect on IN.
- R5: A valid OUT token with data_crc_ok 0 gets no reply. With good data it gets STALL if halted, otherwise NAK if ep_ready is 0, otherwise ACK.
- R6: An ACKed OUT whose rx_toggle equals exp_toggle raises data_accept, and exp_toggle inverts. An ACKed OUT with a mismatched toggle is still ACKed, but data_accept stays 0 and exp_toggle stays the same. A STALLed, NAKed or silent OUT leaves exp_toggle alone and raises no data_accept.
- R7: On a control endpoint (is_control 1), a valid SETUP with good data always gets ACK, whatever halted and ep_ready are. It raises data_accept and toggle_reset, sets exp_toggle to 1 (DATA1) and clears halted. A SETUP with bad data gets no reply and changes nothing.
- R8: On a non-control endpoint, a SETUP gets no reply, raises no strobe, and changes neither halted nor exp_toggle.
- R9: A reserved PID (3) gets no reply and changes no state.
- R10: halt_set makes halted 1 in the next cycle, and halt_clr makes it 0. When both are 1, halt_set wins. halt_set also wins over the clear done by a SETUP in the same cycle.
- R11: toggle_reset is 1 only in the response cycle of an accepted SETUP (R7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_done | input | 1 | Transaction inputs are valid this cycle |
| pid | input | 2 | Decoded token PID (0 OUT, 1 IN, 2 SETUP, 3 reserved) |
| token_ok | input | 1 | Token arrived uncorrupted |
| data_crc_ok | input | 1 | Received data packet passed CRC |
| rx_toggle | input | 1 | Toggle of the received data packet (0 DATA0, 1 DATA1) |
| is_control | input | 1 | Endpoint is a control endpoint |
| ep_ready | input | 1 | Endpoint has data to send (IN) or buffer space (OUT) |
| halt_set | input | 1 | Set the halt condition |
| halt_clr | input | 1 | Clear the halt condition |
| rsp_valid | output | 1 | Reply decision strobe |
| rsp_code | output | 3 | Reply code |
| data_accept | output | 1 | Write the received data into the endpoint buffer |
| toggle_reset | output | 1 | SETUP resynchronised the data toggle |
| exp_toggle | output | 1 | Next expected OUT data toggle |
| halted | output | 1 | Endpoint halt condition |

## Verification
The bench drives a halted control endpoint with a SETUP. A design that let the halt take priority would reply STALL where ACK is required, and would leave the endpoint stuck. It also sends SETUP to a non-control endpoint, where a careless design would ACK, reset the toggle or clear the halt. Repeated OUT packets with equal and flipped toggles show whether a design discards duplicate data while still acknowledging it. A design that flipped the toggle on every ACK would drift out of step with the host. Corrupted tokens and corrupted data go in with every PID and every state, together with overlapping halt set and clear pulses. This exposes a wrong priority order or state that changes on a silent transaction.

// File: rtl/usb_ep_responder.sv
module usb_ep_responder #(
  parameter int PID_W  = 2,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phase_done,
  input  logic [PID_W-1:0]  pid,
  input  logic              token_ok,
  input  logic              data_crc_ok,
  input  logic              rx_toggle,
  input  logic              is_control,
  input  logic              ep_ready,
  input  logic              halt_set,
  input  logic              halt_clr,
  output logic              rsp_valid,
  output logic [CODE_W-1:0] rsp_code,
  output logic              data_accept,
  output logic              toggle_reset,
  output logic              exp_toggle,
  output logic              halted
);
  localparam logic [PID_W-1:0]  PID_OUT   = PID_W'(0);
  localparam logic [PID_W-1:0]  PID_IN    = PID_W'(1);
  localparam logic [PID_W-1:0]  PID_SETUP = PID_W'(2);
  localparam logic [CODE_W-1:0] R_NONE  = CODE_W'(0);
  localparam logic [CODE_W-1:0] R_DATA  = CODE_W'(1);
  localparam logic [CODE_W-1:0] R_ACK   = CODE_W'(2);
  localparam logic [CODE_W-1:0] R_NAK   = CODE_W'(3);
  localparam logic [CODE_W-1:0] R_STALL = CODE_W'(4);

  logic [CODE_W-1:0] reply;
  logic              take, flip, setup_ok;

  wire busy_reply = halted | ~ep_ready;
  wire [CODE_W-1:0] gate_reply = halted ? R_STALL : R_NAK;

  always_comb begin
    reply    = R_NONE;
    take     = 1'b0;
    flip     = 1'b0;
    setup_ok = 1'b0;
    if (token_ok) begin
      unique case (pid)
        PID_IN:    reply = busy_reply ? gate_reply : R_DATA;
        PID_OUT:   if (data_crc_ok) begin
                     reply = busy_reply ? gate_reply : R_ACK;
                     take  = ~busy_reply & (rx_toggle == exp_toggle);
                     flip  = take;
                   end
        PID_SETUP: if (data_crc_ok && is_control) begin
                     reply    = R_ACK;
                     take     = 1'b1;
                     setup_ok = 1'b1;
                   end
        default:   reply = R_NONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_code     <= R_NONE;
      data_accept  <= 1'b0;
      toggle_reset <= 1'b0;
      exp_toggle   <= 1'b0;
      halted       <= 1'b0;
    end else begin
      rsp_valid    <= phase_done;
      rsp_code     <= phase_done ? reply : R_NONE;
      data_accept  <= phase_done & take;
      toggle_reset <= phase_done & setup_ok;
      if (phase_done && setup_ok)  exp_toggle <= 1'b1;
      else if (phase_done && flip) exp_toggle <= ~exp_toggle;
      halted <= halt_set | (halted & ~halt_clr & ~(phase_done & setup_ok));
    end
  end
endmodule

module usb_ep_responder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       phase_done,
  input logic [1:0] pid,
  input logic       token_ok,
  input logic       data_crc_ok,
  input logic       is_control,
  input logic       halt_set,
  input logic       halt_clr,
  input logic       rsp_valid,
  input logic [2:0] rsp_code,
  input logic       data_accept,
  input logic       toggle_reset,
  input logic       exp_toggle,
  input logic       halted
);
  assert_strobe_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    phase_done |=> rsp_valid);
  assert_no_stray_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_done |=> !rsp_valid && rsp_code == 3'd0);
  assert_bad_token_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phase_done && !token_ok |=> rsp_code == 3'd0 && !data_accept && $stable(exp_toggle));
  assert_setup_acked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    phase_done && token_ok && pid == 2'd2 && is_control && data_crc_ok && !halt_set
    |=> rsp_code == 3'd2 && data_accept && exp_toggle && !halted);
  assert_setup_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    phase_done && pid == 2'd2 && !is_control && !halt_set && !halt_clr
    |=> rsp_code == 3'd0 && !toggle_reset && $stable(exp_toggle) && $stable(halted));
  assert_accept_only_on_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    data_accept |-> rsp_valid && rsp_code == 3'd2);
  assert_reset_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    toggle_reset |-> data_accept && exp_toggle);
  assert_halt_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halt_set |=> halted);
endmodule

bind usb_ep_responder usb_ep_responder_chk u_chk (.*);

// File: tb/usb_ep_responder_test.sv
module usb_ep_responder_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic phase_done = 0, token_ok = 0, data_crc_ok = 0, rx_toggle = 0;
  logic is_control = 0, ep_ready = 0, halt_set = 0, halt_clr = 0;
  logic [1:0] pid = 0;
  logic rsp_valid, data_accept, toggle_reset, exp_toggle, halted;
  logic [2:0] rsp_code;

  integer n_cmp = 0, n_bad = 0;
  int m_code = 0;
  bit m_valid = 0, m_acc = 0, m_trst = 0, m_tog = 0, m_halt = 0;
  string m_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_ep_responder uut (.*);

  task automatic chk(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", m_tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("rsp_valid", rsp_valid, m_valid);
    chk("rsp_code", rsp_code, m_code);
    chk("data_accept", data_accept, m_acc);
    chk("toggle_reset", toggle_reset, m_trst);
    chk("exp_toggle", exp_toggle, m_tog);
    chk("halted", halted, m_halt);
  endtask

  // Drive one cycle, predict the outcome from the requirements, compare after the edge.
  task automatic step(bit pd, int p, bit tok, bit crc, bit rt, bit ctl, bit rdy, bit hs, bit hc);
    bit nh;
    phase_done = pd; pid = 2'(p); token_ok = tok; data_crc_ok = crc;
    rx_toggle = rt; is_control = ctl; ep_ready = rdy; halt_set = hs; halt_clr = hc;
    m_valid = pd; m_code = 0; m_acc = 0; m_trst = 0; m_tag = "R2";
    nh = m_halt;
    if (hc) nh = 0;
    if (pd) begin
      if (!tok) m_tag = "R3";
      else if (p == 1) begin
        m_tag = "R4";
        m_code = m_halt ? 4 : (!rdy ? 3 : 1);
      end else if (p == 0) begin
        m_tag = "R5";
        if (crc) begin
          m_code = m_halt ? 4 : (!rdy ? 3 : 2);
          if (m_code == 2) begin
            m_tag = "R6";
            if (rt == m_tog) begin m_acc = 1; m_tog = !m_tog; end
          end
        end
      end else if (p == 2) begin
        m_tag = ctl ? "R7" : "R8";
        if (ctl && crc) begin
          m_code = 2; m_acc = 1; m_trst = 1; m_tog = 1; nh = 0;
        end
      end else m_tag = "R9";
    end
    if (hs) begin nh = 1; m_tag = "R10"; end
    m_halt = nh;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    m_tag = "R1"; compare_all();             // R1 outputs during reset
    rst_n = 1'b1;
    step(0,0,0,0,0,0,0,0,0);                 // R1 idle after reset
    // R4 IN variants
    step(1,1,1,0,0,0,1,0,0);                 // data, crc ignored
    step(1,1,1,1,0,0,0,0,0);                 // NAK
    step(1,1,0,1,0,0,1,0,0);                 // R3 corrupted token
    // R5/R6 OUT
    step(1,0,1,0,0,0,1,0,0);                 // bad crc silent
    step(1,0,1,1,0,0,1,0,0);                 // toggle match -> flip
    step(1,0,1,1,0,0,1,0,0);                 // R6 mismatch: ACK, discard
    step(1,0,1,1,1,0,0,0,0);                 // NAK
    step(0,0,0,0,0,0,0,1,1);                 // R10 set beats clear
    step(1,0,1,1,1,1,1,0,0);                 // STALL
    step(1,1,1,1,0,1,1,0,0);                 // IN STALL
    step(1,2,1,1,0,0,1,0,0);                 // R8 non-control SETUP ignored
    step(1,2,1,0,0,1,1,0,0);                 // R7 bad-data SETUP silent
    step(1,2,1,1,0,1,0,0,0);                 // R7 halted busy control SETUP ACKed
    step(1,3,1,1,0,1,1,0,0);                 // R9 reserved PID
    step(1,2,1,1,0,1,1,1,0);                 // R10 set beats SETUP clear
    step(0,0,0,0,0,0,0,0,1);                 // R10 clear
    step(1,0,1,1,1,1,1,0,0);                 // R11 no toggle_reset on OUT
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom;
      step(r[0] | r[1], r[3:2], r[4] | r[5], r[6] | r[7], r[8], r[9],
           r[10] | r[11], (r[15:12] == 0), (r[19:16] == 0));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule